// File: doc/BRIEF.md
# SPI Slave with Per-Word Enable Handshake

This block is the slave end of a five-wire serial link: serial clock, master-out data, slave-out data, an active-low select, and an active-low enable line that the slave uses to pace the master one word at a time. Local logic offers a transmit word on a valid/ready port. Once that word sits in the shift register and the slave is selected, the enable line goes low and the master may clock the word. Data moves most significant bit first in both directions. When the last bit has been sampled, the slave raises the enable line again and posts the received word with a one-cycle strobe. It keeps the enable line high until local logic loads the next word, so a slow local side simply stalls the master between words.

All serial inputs are resynchronised into the system clock, and the clock edges are found there. The enable pad can run in one of two modes. In the driven mode it is always driven. In the release mode it is driven low only while ready and left undriven otherwise, so several slaves can share one pulled-up enable wire.

Top module: `spi_flow_slave`

## Requirements
- R1: After reset, tx_ready is 1, rx_valid is 0, spi_ena_n is 1, and spi_ena_oe is 1 when ena_release is 0.
- R2: tx_ready is 1 exactly when no word is waiting in the shift register. A word is taken on a clock edge where tx_valid and tx_ready are both 1, and tx_ready is 0 from the following cycle. tx_valid while tx_ready is 0 has no effect on the word that is sent.
- R3: spi_ena_n is 0 only while a loaded word is pending and the synchronised spi_cs_n is 0. A change on spi_cs_n reaches spi_ena_n two system cycles after it is applied. With no word loaded, spi_ena_n stays 1 even while selected.
- R4: In the cycle in which rx_valid is 1, spi_ena_n is 1 and tx_ready is 1 again. spi_ena_n stays 1 until a new word is loaded.
- R5: While spi_cs_n is 1, spi_ena_n is 1 whatever the transmit state. Deselecting in the middle of a word abandons the partial word and keeps the loaded word. The next selection sends that word again from its MSB.
- R6: ena_release = 1 selects release mode: spi_ena_oe is 0 whenever spi_ena_n is 1, and is 1 while ready (spi_ena_n = 0). ena_release = 0 keeps spi_ena_oe at 1.
- R7: Both directions are MSB first. spi_mosi is sampled on a rising spi_sclk and spi_miso changes only after a falling spi_sclk that follows a sampled bit. The first MSB is on spi_miso as soon as the word is loaded. rx_data equals the WORD_W bits sampled.
- R8: rx_valid is a single-cycle pulse. It appears three system cycles after the rising spi_sclk of the final bit is applied, with rx_data valid in the same cycle.
- R9: spi_sclk edges while no word is loaded are ignored: no rx_valid pulse, and tx_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | WORD_W | Word to send next |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Shift register free; word taken on valid and ready |
| rx_data | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe with rx_data |
| ena_release | input | 1 | 1 = release the enable pad when not ready, 0 = always drive it |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the master |
| spi_ena_n | output | 1 | Active-low ready toward the master (pad value) |
| spi_ena_oe | output | 1 | Output enable of the enable pad |

## Verification
Every serial input passes through a two-flop synchroniser and one edge register. A select change therefore shows on the enable line two cycles later. A rising clock edge yields rx_valid, the new rx_data and the released enable three cycles later, and a falling edge moves spi_miso three cycles later. A load on the port shows on tx_ready in the next cycle. The bench drives inputs at the falling clock edge and counts falling edges before it samples. It checks both sides of each deadline, for example the enable still high one cycle after select and low one cycle later. It samples spi_miso only after the data has settled, and looks for rx_valid in both the due cycle and the cycle after it.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {
    ENA_DRIVEN   = 1'b0,
    ENA_RELEASED = 1'b1
  } ena_mode_e;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              selected,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_bit,
  output logic              word_armed,
  output logic              miso_bit,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] acc,
                                                 input logic b);
    return {acc[WORD_W-2:0], b};
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] idx);
    return idx == LAST_IDX;
  endfunction

  logic [WORD_W-1:0] tx_sh, tx_keep, rx_sh, rx_next;
  logic [CNT_W-1:0]  bit_idx;
  logic              armed, sampled_half;
  logic              accept, sample_evt, shift_evt, abort_evt;

  assign tx_ready   = ~armed;
  assign accept     = tx_valid & tx_ready;
  assign abort_evt  = armed & ~selected;
  assign sample_evt = armed & selected & sclk_rise;
  assign shift_evt  = armed & selected & sclk_fall & sampled_half;
  assign rx_next    = shift_in(rx_sh, mosi_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      tx_sh        <= '0;
      tx_keep      <= '0;
      rx_sh        <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      bit_idx      <= '0;
      sampled_half <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (accept) begin
        tx_sh        <= tx_data;
        tx_keep      <= tx_data;
        armed        <= 1'b1;
        bit_idx      <= '0;
        sampled_half <= 1'b0;
      end else if (abort_evt) begin
        tx_sh        <= tx_keep;
        bit_idx      <= '0;
        sampled_half <= 1'b0;
      end else if (sample_evt) begin
        rx_sh        <= rx_next;
        sampled_half <= 1'b1;
        if (is_last(bit_idx)) begin
          rx_data  <= rx_next;
          rx_valid <= 1'b1;
          armed    <= 1'b0;
          bit_idx  <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end else if (shift_evt) begin
        tx_sh        <= {tx_sh[WORD_W-2:0], 1'b0};
        sampled_half <= 1'b0;
      end
    end
  end

  assign word_armed = armed;
  assign miso_bit   = tx_sh[WORD_W-1];

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_done_frees_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (tx_ready && !word_armed));

  p_idle_clock_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !accept) |=> !rx_valid);
endmodule

// File: rtl/sfs_ena_ctrl.sv
module sfs_ena_ctrl
  import sfs_pkg::*;
(
  input  logic word_armed,
  input  logic selected,
  input  logic release_mode,
  output logic ena_n,
  output logic ena_oe
);
  ena_mode_e mode;
  logic      ready;

  assign mode   = ena_mode_e'(release_mode);
  assign ready  = word_armed & selected;
  assign ena_n  = ~ready;
  assign ena_oe = ready | (mode == ENA_DRIVEN);
endmodule

// File: rtl/spi_flow_slave.sv
module spi_flow_slave #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              ena_release,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              spi_ena_n,
  output logic              spi_ena_oe
);
  logic [2:0] pins_sync;
  logic       sclk_s, mosi_s, cs_n_s, sclk_prev;
  logic       sclk_rise, sclk_fall, selected, word_armed;

  sfs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sclk, spi_mosi, spi_cs_n}),
    .q    (pins_sync)
  );

  assign {sclk_s, mosi_s, cs_n_s} = pins_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;
  assign selected  = ~cs_n_s;

  sfs_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .selected  (selected),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_bit  (mosi_s),
    .word_armed(word_armed),
    .miso_bit  (spi_miso),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

  sfs_ena_ctrl u_ena (
    .word_armed  (word_armed),
    .selected    (selected),
    .release_mode(ena_release),
    .ena_n       (spi_ena_n),
    .ena_oe      (spi_ena_oe)
  );

  p_ena_needs_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_ena_n |-> (!cs_n_s && !tx_ready));

  p_deselect_ena_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> spi_ena_n);

  p_release_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_release && spi_ena_n) |-> !spi_ena_oe);

  p_miso_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !$past(sclk_fall) && !$past(cs_n_s) && !cs_n_s && $past(!tx_ready))
      |-> $stable(spi_miso));
endmodule

// File: tb/spi_flow_slave_bench.sv
module spi_flow_slave_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [W-1:0] rx_data;
  logic         rx_valid;
  logic         ena_release = 1'b0;
  logic         spi_sclk = 1'b0;
  logic         spi_mosi = 1'b0;
  logic         spi_cs_n = 1'b1;
  logic         spi_miso, spi_ena_n, spi_ena_oe;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  spi_flow_slave #(.WORD_W(W)) u_spi_flow_slave (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .ena_release(ena_release), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_ena_n(spi_ena_n),
    .spi_ena_oe(spi_ena_oe)
  );

  // upper half: word loaded for sending, lower half: word the master sends
  localparam logic [31:0] VEC [4] = '{
    32'hA5C3_3C5A, 32'h0001_FFFE, 32'h8000_0001, 32'hFFFF_0000
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] w);
    tx_data  = w;
    tx_valid = 1'b1;
    wait_n(1);
    tx_valid = 1'b0;
  endtask

  // one bit from the master; returns what the slave showed and did
  task automatic clock_bit(input logic b, output logic miso_seen,
                           output logic v_due, output logic v_after,
                           output logic ena_due, output logic rdy_due,
                           output logic [W-1:0] data_due);
    spi_mosi = b;
    wait_n(4);
    miso_seen = spi_miso;
    spi_sclk = 1'b1;
    wait_n(3);
    v_due = rx_valid; ena_due = spi_ena_n; rdy_due = tx_ready; data_due = rx_data;
    wait_n(1);
    v_after = rx_valid;
    spi_sclk = 1'b0;
    wait_n(4);
  endtask

  // full word; checks R3/R4/R7/R8 along the way
  task automatic run_word(input logic [W-1:0] mosi_w, input logic [W-1:0] exp_tx,
                          input string tag);
    logic [W-1:0] miso_acc, data_due;
    logic m, vd, va, ed, rd;
    int pulses;
    miso_acc = '0; pulses = 0;
    for (int k = W - 1; k >= 0; k--) begin
      clock_bit(mosi_w[k], m, vd, va, ed, rd, data_due);
      miso_acc = {miso_acc[W-2:0], m};
      if (vd) pulses++;
      if (k != 0) begin
        chk(ed == 1'b0, {tag, " R3 ena low mid-word"}, 32'(ed), 32'd0);
        chk(vd == 1'b0, {tag, " R8 no early strobe"}, 32'(vd), 32'd0);
      end else begin
        chk(vd == 1'b1, {tag, " R8 strobe due"}, 32'(vd), 32'd1);
        chk(va == 1'b0, {tag, " R8 strobe one cycle"}, 32'(va), 32'd0);
        chk(data_due == mosi_w, {tag, " R7 rx data"}, 32'(data_due), 32'(mosi_w));
        chk(ed == 1'b1, {tag, " R4 ena high at strobe"}, 32'(ed), 32'd1);
        chk(rd == 1'b1, {tag, " R4 ready at strobe"}, 32'(rd), 32'd1);
      end
    end
    chk(pulses == 1, {tag, " R8 pulse count"}, 32'(pulses), 32'd1);
    chk(miso_acc == exp_tx, {tag, " R7 miso word"}, 32'(miso_acc), 32'(exp_tx));
  endtask

  initial begin
    wait_n(50000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic m, vd, va, ed, rd;
    logic [W-1:0] dd;
    int seen;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    chk(tx_ready == 1'b1, "R1 ready", 32'(tx_ready), 32'd1);
    chk(rx_valid == 1'b0, "R1 valid", 32'(rx_valid), 32'd0);
    chk(spi_ena_n == 1'b1, "R1 ena", 32'(spi_ena_n), 32'd1);
    chk(spi_ena_oe == 1'b1, "R1 oe", 32'(spi_ena_oe), 32'd1);

    // R3/R9: selected, no word loaded, master clocks anyway
    spi_cs_n = 1'b0;
    wait_n(3);
    chk(spi_ena_n == 1'b1, "R3 no word no ena", 32'(spi_ena_n), 32'd1);
    seen = 0;
    for (int k = 0; k < W; k++) begin
      clock_bit(1'b1, m, vd, va, ed, rd, dd);
      if (vd || va) seen++;
    end
    chk(seen == 0, "R9 idle clocks no strobe", 32'(seen), 32'd0);
    chk(tx_ready == 1'b1, "R9 ready kept", 32'(tx_ready), 32'd1);
    spi_cs_n = 1'b1;
    wait_n(3);

    // table walk
    for (int i = 0; i < 4; i++) begin
      ena_release = i[0];
      load_word(VEC[i][31:16]);
      chk(tx_ready == 1'b0, "R2 ready drops", 32'(tx_ready), 32'd0);
      chk(spi_ena_n == 1'b1, "R5 deselected ena high", 32'(spi_ena_n), 32'd1);
      chk(spi_ena_oe == !ena_release, "R6 oe idle", 32'(spi_ena_oe), 32'(!ena_release));
      spi_cs_n = 1'b0;
      wait_n(1);
      chk(spi_ena_n == 1'b1, "R3 ena latency early", 32'(spi_ena_n), 32'd1);
      wait_n(1);
      chk(spi_ena_n == 1'b0, "R3 ena low when ready", 32'(spi_ena_n), 32'd0);
      chk(spi_ena_oe == 1'b1, "R6 oe when ready", 32'(spi_ena_oe), 32'd1);
      run_word(VEC[i][15:0], VEC[i][31:16], "vec");
      chk(spi_ena_oe == !ena_release, "R6 oe after word", 32'(spi_ena_oe),
          32'(!ena_release));
      wait_n(6);
      chk(spi_ena_n == 1'b1, "R4 ena held until load", 32'(spi_ena_n), 32'd1);
      spi_cs_n = 1'b1;
      wait_n(3);
    end

    // R5 abort mid-word, R2 ignored offer while busy
    ena_release = 1'b0;
    load_word(16'hC0DE);
    tx_data = 16'h1234; tx_valid = 1'b1;
    wait_n(2);
    tx_valid = 1'b0;
    spi_cs_n = 1'b0;
    wait_n(3);
    for (int k = 0; k < 5; k++) clock_bit(1'b0, m, vd, va, ed, rd, dd);
    spi_cs_n = 1'b1;
    wait_n(1);
    chk(spi_ena_n == 1'b0, "R5 deselect latency early", 32'(spi_ena_n), 32'd0);
    wait_n(1);
    chk(spi_ena_n == 1'b1, "R5 deselect ena high", 32'(spi_ena_n), 32'd1);
    chk(tx_ready == 1'b0, "R5 word kept", 32'(tx_ready), 32'd0);
    spi_cs_n = 1'b0;
    wait_n(3);
    run_word(16'h5AA5, 16'hC0DE, "abort R5 R2");
    spi_cs_n = 1'b1;
    wait_n(3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule